// File: doc/BRIEF.md
# Shared Interrupt Control and Status Register

This block is a single 16-bit control and status register. It merges three interrupt sources into one processor interrupt line: the signal-processor core, the auxiliary-memory DMA engine and the audio DMA. Each source has a status bit and an enable bit. The enable bit sits in the position directly above its status bit, so the merged interrupt is the OR over all sources of (register shifted right by one) AND register AND the status-bit mask. A one-cycle event pulse from hardware sets a status bit. Software clears a status bit by writing 1 to it.

All other fields are plain read/write storage: the core reset, assert, halt and init controls, the init code and the padding bits. The exception is the DMA-busy bit, which follows a level from the DMA engine. A write that sets bit 0 also sends a one-cycle clear strobe to the audio DMA control word. A write that puts non-zero data in the padding bits raises an error strobe, and the padding bits are still stored as written. All outputs are registered.

Top module: `irq_csr`

## Requirements
- R1: After synchronous reset, rd_data reads 0x0004 (only the halt bit, bit 2, is set), and irq_out, adma_clr and pad_err are low.
- R2: A high evt_pulse[i] at a clock edge sets status bit 3+2*i (bit 3 for the core, bit 5 for the auxiliary DMA, bit 7 for audio) at that edge. Events change no other bit.
- R3: A write with a 1 in a status bit position clears that status bit. A 0 in that position leaves the bit unchanged.
- R4: When an event and a write-one clear hit the same status bit in the same cycle, the status bit ends up set.
- R5: The enable bit of each source is status bit + 1 (bits 4, 6, 8). irq_out is high exactly when some status bit and its enable bit are both set in rd_data. irq_out updates on the same edge as rd_data.
- R6: Bits 0, 1, 2, 4, 6, 8, 10, 11 and 15:12 are plain read/write: a write stores wr_data there and they keep their value otherwise.
- R7: Bit 9 shows dma_busy as sampled at the previous edge. Writes to bit 9 have no effect.
- R8: A write with wr_data[0]=1 gives adma_clr high for exactly the one cycle after that edge. Otherwise adma_clr is low.
- R9: A write with any of wr_data[15:12] non-zero gives pad_err high for the one cycle after that edge, and those bits are stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Write data |
| evt_pulse | input | 3 | Event pulses: 0 core, 1 auxiliary DMA, 2 audio DMA |
| dma_busy | input | 1 | Auxiliary DMA busy level |
| rd_data | output | 16 | Register contents |
| irq_out | output | 1 | Merged interrupt, registered |
| adma_clr | output | 1 | Audio DMA control clear strobe |
| pad_err | output | 1 | Padding-bits-written strobe |

## Verification
The bench builds the block with its default three sources and 16-bit width. With these values every status/enable pair, the busy bit and the four padding bits have fixed positions that the bench can model bit by bit. Random writes are biased to leave status bits alone, so events can pile up across sources while enables toggle. This exercises every combination of pending and enabled sources. Directed cases cover a clear and an event landing on the same bit in the same cycle, and writes that target the busy bit.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  // Bits 0..2 are reset, assert and halt controls.
  localparam int CTRL_BITS = 3;
  localparam logic [CTRL_BITS-1:0] CTRL_RST = 3'b100;

  function automatic int stat_pos(input int idx);
    return CTRL_BITS + 2 * idx;
  endfunction

  function automatic int busy_pos(input int nsrc);
    return CTRL_BITS + 2 * nsrc;
  endfunction

  // Init bit and init-code bit follow the busy bit, then the padding.
  function automatic int pad_lo(input int nsrc);
    return busy_pos(nsrc) + 3;
  endfunction
endpackage

// File: rtl/irq_csr_field.sv
module irq_csr_field #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_en) q <= wr_val;
  end
endmodule

// File: rtl/irq_csr_pair.sv
module irq_csr_pair (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_clr,
  input  logic wr_msk,
  input  logic evt,
  output logic stat_q,
  output logic mask_q,
  output logic hit_nx
);
  logic stat_nx, mask_nx;

  // Event set has priority over write-one-to-clear.
  assign stat_nx = evt | (stat_q & ~(wr_en & wr_clr));
  assign mask_nx = wr_en ? wr_msk : mask_q;
  assign hit_nx  = stat_nx & mask_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      mask_q <= mask_nx;
    end
  end
endmodule

// File: rtl/irq_csr_side.sv
module irq_csr_side #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_rst_bit,
  input  logic [PW-1:0] wr_pad,
  input  logic          busy_in,
  output logic          busy_q,
  output logic          adma_clr_q,
  output logic          pad_err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      adma_clr_q <= 1'b0;
      pad_err_q  <= 1'b0;
    end else begin
      busy_q     <= busy_in;
      adma_clr_q <= wr_en & wr_rst_bit;
      pad_err_q  <= wr_en & (|wr_pad);
    end
  end
endmodule

// File: rtl/irq_csr.sv
module irq_csr #(
  parameter int NUM_SRC = 3,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic               dma_busy,
  output logic [REG_W-1:0]   rd_data,
  output logic               irq_out,
  output logic               adma_clr,
  output logic               pad_err
);
  import irq_csr_pkg::*;

  localparam int BUSY_B = busy_pos(NUM_SRC);
  localparam int HI_LO  = BUSY_B + 1;
  localparam int HI_W   = REG_W - HI_LO;
  localparam int PAD_L  = pad_lo(NUM_SRC);
  localparam int PAD_W  = REG_W - PAD_L;

  logic [NUM_SRC-1:0] hit_vec;
  logic               irq_q;
  logic               busy_q;

  irq_csr_field #(.W(CTRL_BITS), .RST_VAL(CTRL_RST)) u_lo (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_val(wr_data[CTRL_BITS-1:0]), .q(rd_data[CTRL_BITS-1:0])
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int SP = stat_pos(i);
    irq_csr_pair u_pair (
      .clk(clk), .rst(rst), .wr_en(wr_en),
      .wr_clr(wr_data[SP]), .wr_msk(wr_data[SP+1]),
      .evt(evt_pulse[i]),
      .stat_q(rd_data[SP]), .mask_q(rd_data[SP+1]),
      .hit_nx(hit_vec[i])
    );
  end

  irq_csr_field #(.W(HI_W), .RST_VAL('0)) u_hi (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_val(wr_data[REG_W-1:HI_LO]), .q(rd_data[REG_W-1:HI_LO])
  );

  irq_csr_side #(.PW(PAD_W)) u_side (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_rst_bit(wr_data[0]), .wr_pad(wr_data[REG_W-1:PAD_L]),
    .busy_in(dma_busy), .busy_q(busy_q),
    .adma_clr_q(adma_clr), .pad_err_q(pad_err)
  );

  assign rd_data[BUSY_B] = busy_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |hit_vec;
  end
  assign irq_out = irq_q;
endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk #(
  parameter int NUM_SRC = 3,
  parameter int REG_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic               dma_busy,
  input logic [REG_W-1:0]   rd_data,
  input logic               irq_out,
  input logic               adma_clr,
  input logic               pad_err
);
  import irq_csr_pkg::*;
  localparam int BUSY_B = busy_pos(NUM_SRC);
  localparam int PAD_L  = pad_lo(NUM_SRC);

  function automatic logic [REG_W-1:0] smask();
    logic [REG_W-1:0] m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[stat_pos(i)] = 1'b1;
    return m;
  endfunction
  localparam logic [REG_W-1:0] SMASK = smask();

  assert_reset_val_R1: assert property (@(posedge clk)
    rst |=> (rd_data == {{(REG_W-CTRL_BITS){1'b0}}, CTRL_RST}) && !irq_out && !adma_clr && !pad_err);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_a
    localparam int SP = stat_pos(i);
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
      evt_pulse[i] |=> rd_data[SP]);
    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[SP] && !evt_pulse[i]) |=> !rd_data[SP]);
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_data[SP] && !(wr_en && wr_data[SP])) |=> rd_data[SP]);
  end

  assert_irq_merge_R5: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|((rd_data >> 1) & rd_data & SMASK)));

  assert_busy_follow_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_data[BUSY_B] == $past(dma_busy));

  assert_adma_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[0]) |=> adma_clr);
  assert_adma_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_data[0]) |=> !adma_clr);

  assert_pad_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (|wr_data[REG_W-1:PAD_L])) |=> pad_err && (rd_data[REG_W-1:PAD_L] == $past(wr_data[REG_W-1:PAD_L])));
endmodule

bind irq_csr irq_csr_chk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .evt_pulse(evt_pulse), .dma_busy(dma_busy), .rd_data(rd_data),
  .irq_out(irq_out), .adma_clr(adma_clr), .pad_err(pad_err)
);

// File: tb/irq_csr_test.sv
module irq_csr_test;
  localparam logic [15:0] STAT = 16'h00A8;
  localparam logic [15:0] BUSY = 16'h0200;
  localparam logic [15:0] RWM  = 16'hFD57;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  evt_pulse = '0;
  logic        dma_busy = 1'b0;
  logic [15:0] rd_data;
  logic        irq_out, adma_clr, pad_err;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_r;
  logic        exp_irq, exp_adma, exp_pad;

  always #2 clk = ~clk;

  irq_csr uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .evt_pulse(evt_pulse), .dma_busy(dma_busy), .rd_data(rd_data),
    .irq_out(irq_out), .adma_clr(adma_clr), .pad_err(pad_err)
  );

  function automatic logic [15:0] model_next(input logic [15:0] r, input logic we,
      input logic [15:0] wd, input logic [2:0] ev, input logic busy);
    logic [15:0] n = r;
    if (we) n = (wd & RWM) | (r & STAT & ~wd);
    for (int i = 0; i < 3; i++) if (ev[i]) n[3+2*i] = 1'b1;
    n[9] = busy;
    return n;
  endfunction

  function automatic logic model_irq(input logic [15:0] r);
    return |((r >> 1) & r & STAT);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [15:0] wd, input logic [2:0] ev,
      input logic busy, input string tag);
    wr_en = we; wr_data = wd; evt_pulse = ev; dma_busy = busy;
    exp_r    = model_next(exp_r, we, wd, ev, busy);
    exp_irq  = model_irq(exp_r);
    exp_adma = we & wd[0];
    exp_pad  = we & (|wd[15:12]);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; evt_pulse = '0;
    check({tag, " reg"}, rd_data, exp_r);
    check("R5 irq", {15'd0, irq_out}, {15'd0, exp_irq});
    check("R8 adma_clr", {15'd0, adma_clr}, {15'd0, exp_adma});
    check("R9 pad_err", {15'd0, pad_err}, {15'd0, exp_pad});
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_r = 16'h0004;
    check("R1 reset reg", rd_data, 16'h0004);
    check("R1 reset irq", {15'd0, irq_out}, 16'd0);
    check("R1 reset strobes", {14'd0, adma_clr, pad_err}, 16'd0);

    // R2: core event sets bit 3, no irq without enable (R5)
    step(1'b0, 16'h0000, 3'b001, 1'b0, "R2");
    check("R2 bit3", {15'd0, rd_data[3]}, 16'd1);
    // R6/R5: enable bit 4 -> irq
    step(1'b1, 16'h0014, 3'b000, 1'b0, "R6");
    check("R5 irq on", {15'd0, irq_out}, 16'd1);
    // R3: write 0 to bit 3 leaves it, then write 1 clears
    step(1'b1, 16'h0010, 3'b000, 1'b0, "R3 hold");
    check("R3 hold", {15'd0, rd_data[3]}, 16'd1);
    step(1'b1, 16'h0018, 3'b000, 1'b0, "R3 clr");
    check("R3 clr", {15'd0, rd_data[3]}, 16'd0);
    // R4: audio event with clear same cycle
    step(1'b0, 16'h0000, 3'b100, 1'b0, "R2");
    step(1'b1, 16'h0180, 3'b100, 1'b0, "R4");
    check("R4 set wins", {15'd0, rd_data[7]}, 16'd1);
    // R7: busy follows input, write to bit 9 ignored
    step(1'b1, 16'h0200, 3'b000, 1'b0, "R7 wr");
    check("R7 ignored", {15'd0, rd_data[9]}, 16'd0);
    step(1'b0, 16'h0000, 3'b000, 1'b1, "R7 follow");
    check("R7 follow", {15'd0, rd_data[9]}, 16'd1);
    // R8: reset bit strobe; R9: padding write
    step(1'b1, 16'h0001, 3'b000, 1'b1, "R8");
    step(1'b1, 16'hA000, 3'b010, 1'b0, "R9");
    check("R9 stored", {12'd0, rd_data[15:12]}, 16'h000A);
    check("R2 aux bit5", {15'd0, rd_data[5]}, 16'd1);

    for (int k = 0; k < 400; k++) begin
      logic [15:0] wd = 16'($urandom);
      logic        we = ($urandom % 3) == 0;
      if (($urandom % 4) != 0) wd = wd & ~STAT;
      step(we, wd, 3'($urandom % 8 == 0 ? $urandom : 0), 1'($urandom), "R2/R3/R6");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule